// File: doc/BRIEF.md
# Hardware A20 Gate Sequencer

This block sits next to the host-side input buffer of a slave peripheral controller and decodes one host protocol entirely in hardware: the "write output port" exchange that moves a single gate output bit. The host issues an arming command byte, then a data byte whose bit 1 becomes the new gate level, and optionally a closing command byte. None of these bytes reach the local CPU, so the CPU spends no time on them. While it takes part in such an exchange, the block raises a swallow signal. The neighbouring buffer uses that signal to neither latch the byte nor set its input-buffer-full flag.

The local CPU switches the block on once with a single-cycle enable pulse. After that the gate bit is a dedicated output. Only a valid host exchange can change it, and only a reset can switch the block off again. Host writes are recognised on the rising edge of the write strobe while chip select is low. The strobe, chip select, command/data select and data bus pass through a small synchronizer into the core clock. Each recognised write yields one strobe pulse for the buffer, with the swallow flag beside it.

Top module: `a20_gate_seq`

## Requirements
- R1: While reset is held and after it is released, `gate_out` is 1, `wr_strobe` and `wr_swallow` are 0, and the block is disabled.
- R2: While the block is disabled, every recognised host write produces a `wr_strobe` pulse with `wr_swallow` low, and `gate_out` does not change.
- R3: A one-cycle pulse on `cpu_gate_en` enables the block, and it then stays enabled until reset; a further pulse changes nothing.
- R4: When enabled and not armed, a command write (`host_a0`=1) of D1h arms the sequence and is swallowed.
- R5: A data write (`host_a0`=0) that follows an arming command copies data bit 1 to `gate_out` and is swallowed; the other seven data bits have no effect.
- R6: A command write of FFh directly after a swallowed D1h/data pair is swallowed; an FFh command at any other point is not swallowed.
- R7: A further D1h command while armed is swallowed and leaves the sequence armed, so the next data write still sets the gate.
- R8: A command other than D1h while armed ends the sequence and is not swallowed; the next data write is not swallowed and leaves `gate_out` unchanged.
- R9: Each rising edge of `host_wr_n` seen while `host_cs_n` is low gives exactly one single-cycle `wr_strobe` pulse; strobe edges with `host_cs_n` high give none.
- R10: `wr_swallow` is only high in a cycle where `wr_strobe` is high, and `gate_out` changes only in such a swallowed cycle.
- R11: When enabled, a data write that is not preceded by an arming command is not swallowed and leaves `gate_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_n | input | 1 | Host write strobe, active low; the rising edge completes a write |
| host_cs_n | input | 1 | Host chip select, active low |
| host_a0 | input | 1 | Command/data select: 1 = command byte, 0 = data byte |
| host_data | input | 8 | Host data bus |
| cpu_gate_en | input | 1 | One-cycle enable pulse from the local CPU |
| gate_out | output | 1 | Gate output bit |
| wr_strobe | output | 1 | One-cycle pulse per recognised host write |
| wr_swallow | output | 1 | High with `wr_strobe` when the byte must not reach the input buffer |

## Verification
The bench builds the block with its defaults: an 8-bit bus, two synchronizer stages, the gate on data bit 1, D1h as the arming command and FFh as the closing command. These values make the exchanges reachable as the host protocol defines them. This covers set and clear exchanges, data bytes whose other bits disagree with bit 1, a repeated arming command, an aborting command, stray closing commands and data bytes, and writes with chip select high. Because of the two-stage synchronizer, the bench holds every bus value steady for several clocks around the strobe edge. It then counts strobe and swallow pulses as the buffer would see them.

// File: rtl/a20_gate_pkg.sv
// Package: shared types for the A20 gate sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package a20_gate_pkg;

    // Sequence position of the host "write output port" exchange.
    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,   // waiting for an arming command
        SEQ_ARMED  = 2'd1,   // arming command seen, expecting the data byte
        SEQ_LOADED = 2'd2    // data byte applied, closing command may follow
    } seq_state_t;

    // Control lines of the host bus as sampled in the core clock.
    typedef struct packed {
        logic wr_n;
        logic cs_n;
        logic a0;
    } host_ctl_t;

    localparam host_ctl_t HOST_CTL_IDLE = '{wr_n: 1'b1, cs_n: 1'b1, a0: 1'b0};

endpackage

// File: rtl/host_wr_sampler.sv
// Module: host_wr_sampler
// Brings the asynchronous host write bus into the core clock through a
// SYNC_STAGES deep register chain. One extra stage keeps the previous
// value, so the write strobe's rising edge can be found. A write counts
// when the strobe was low with chip select low in the older sample and is
// high in the newer one. Command/data select and the data byte come from
// the older sample, taken while the strobe was still active.
// Assumes: the host keeps a0, data and cs_n steady for at least
// SYNC_STAGES+1 core clocks around the strobe's rising edge.
module host_wr_sampler
    import a20_gate_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic              cs_n,
    input  logic              a0,
    input  logic [DATA_W-1:0] data,
    output logic              evt_valid,
    output logic              evt_is_cmd,
    output logic [DATA_W-1:0] evt_data
);

    localparam int DEPTH = SYNC_STAGES + 1;
    localparam int NEWER = SYNC_STAGES - 1;
    localparam int OLDER = SYNC_STAGES;

    host_ctl_t         ctl_pipe [DEPTH];
    logic [DATA_W-1:0] dat_pipe [DEPTH];
    logic              edge_hit;

    // Shift the bus samples down the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < DEPTH; s++) begin
                ctl_pipe[s] <= HOST_CTL_IDLE;
                dat_pipe[s] <= '0;
            end
        end else begin
            ctl_pipe[0] <= '{wr_n: wr_n, cs_n: cs_n, a0: a0};
            dat_pipe[0] <= data;
            for (int s = 1; s < DEPTH; s++) begin
                ctl_pipe[s] <= ctl_pipe[s-1];
                dat_pipe[s] <= dat_pipe[s-1];
            end
        end
    end

    // Find a strobe rising edge that was qualified by chip select.
    always_comb begin
        edge_hit = !ctl_pipe[OLDER].wr_n && ctl_pipe[NEWER].wr_n && !ctl_pipe[OLDER].cs_n;
    end

    // Register the recognised write for the sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_valid  <= 1'b0;
            evt_is_cmd <= 1'b0;
            evt_data   <= '0;
        end else begin
            evt_valid  <= edge_hit;
            evt_is_cmd <= ctl_pipe[OLDER].a0;
            evt_data   <= dat_pipe[OLDER];
        end
    end

endmodule

// File: rtl/cpu_enable_latch.sv
// Module: cpu_enable_latch
// Holds the one-way enable of the gate sequencer. A single-cycle pulse
// from the local CPU sets it. After that only reset clears it.
// Assumes: the pulse is synchronous to clk.
module cpu_enable_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic en_pulse,
    output logic en_q
);

    // Sticky enable: set by the pulse, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (en_pulse) begin
            en_q <= 1'b1;
        end
    end

endmodule

// File: rtl/gate_seq_ctrl.sv
// Module: gate_seq_ctrl
// Follows the host arm/data/close exchange, drives the gate bit and flags
// the bytes that must stay hidden from the input buffer. While disabled
// it stays idle and swallows nothing.
// Assumes: evt_valid is a single-cycle pulse from host_wr_sampler.
module gate_seq_ctrl
    import a20_gate_pkg::*;
#(
    parameter int                DATA_W    = 8,
    parameter int                GATE_BIT  = 1,
    parameter logic [DATA_W-1:0] ARM_CMD   = 8'hD1,
    parameter logic [DATA_W-1:0] CLOSE_CMD = 8'hFF,
    parameter logic              GATE_RST  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enabled,
    input  logic              evt_valid,
    input  logic              evt_is_cmd,
    input  logic [DATA_W-1:0] evt_data,
    output logic              gate_q,
    output logic              strobe_q,
    output logic              swallow_q
);

    seq_state_t state_q;
    seq_state_t state_d;
    logic       gate_d;
    logic       take;
    logic       is_arm;
    logic       is_close;

    // Decode the two command values of interest.
    always_comb begin
        is_arm   = evt_is_cmd && (evt_data == ARM_CMD);
        is_close = evt_is_cmd && (evt_data == CLOSE_CMD);
    end

    // Next-state, gate and swallow decision for one recognised write.
    always_comb begin
        state_d = state_q;
        gate_d  = gate_q;
        take    = 1'b0;
        if (enabled && evt_valid) begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (is_arm) begin
                        state_d = SEQ_ARMED;
                        take    = 1'b1;
                    end
                end
                SEQ_ARMED: begin
                    if (!evt_is_cmd) begin
                        gate_d  = evt_data[GATE_BIT];
                        state_d = SEQ_LOADED;
                        take    = 1'b1;
                    end else if (is_arm) begin
                        take    = 1'b1;
                    end else begin
                        state_d = SEQ_IDLE;
                    end
                end
                SEQ_LOADED: begin
                    if (is_close) begin
                        state_d = SEQ_IDLE;
                        take    = 1'b1;
                    end else if (is_arm) begin
                        state_d = SEQ_ARMED;
                        take    = 1'b1;
                    end else begin
                        state_d = SEQ_IDLE;
                    end
                end
                default: state_d = SEQ_IDLE;
            endcase
        end
    end

    // Register sequence state, gate level and the per-write outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= SEQ_IDLE;
            gate_q    <= GATE_RST;
            strobe_q  <= 1'b0;
            swallow_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            gate_q    <= gate_d;
            strobe_q  <= evt_valid;
            swallow_q <= take;
        end
    end

endmodule

// File: rtl/a20_gate_seq.sv
// Module: a20_gate_seq (top)
// Hardware sequencer for the host "write output port" exchange. Host
// writes are synchronised and edge-detected. The sequencer is enabled once
// by the local CPU and drives the gate bit. Each recognised write leaves
// as one wr_strobe pulse, and wr_swallow marks the bytes the input buffer
// must drop.
// Assumes: host bus timing as stated in host_wr_sampler.
module a20_gate_seq
#(
    parameter int                DATA_W      = 8,
    parameter int                SYNC_STAGES = 2,
    parameter int                GATE_BIT    = 1,
    parameter logic [DATA_W-1:0] ARM_CMD     = 8'hD1,
    parameter logic [DATA_W-1:0] CLOSE_CMD   = 8'hFF,
    parameter logic              GATE_RST    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_n,
    input  logic              host_cs_n,
    input  logic              host_a0,
    input  logic [DATA_W-1:0] host_data,
    input  logic              cpu_gate_en,
    output logic              gate_out,
    output logic              wr_strobe,
    output logic              wr_swallow
);

    logic              evt_valid;
    logic              evt_is_cmd;
    logic [DATA_W-1:0] evt_data;
    logic              gate_enabled;

    host_wr_sampler #(
        .DATA_W      (DATA_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_n       (host_wr_n),
        .cs_n       (host_cs_n),
        .a0         (host_a0),
        .data       (host_data),
        .evt_valid  (evt_valid),
        .evt_is_cmd (evt_is_cmd),
        .evt_data   (evt_data)
    );

    cpu_enable_latch u_enable (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_pulse (cpu_gate_en),
        .en_q     (gate_enabled)
    );

    gate_seq_ctrl #(
        .DATA_W    (DATA_W),
        .GATE_BIT  (GATE_BIT),
        .ARM_CMD   (ARM_CMD),
        .CLOSE_CMD (CLOSE_CMD),
        .GATE_RST  (GATE_RST)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .enabled    (gate_enabled),
        .evt_valid  (evt_valid),
        .evt_is_cmd (evt_is_cmd),
        .evt_data   (evt_data),
        .gate_q     (gate_out),
        .strobe_q   (wr_strobe),
        .swallow_q  (wr_swallow)
    );

endmodule

// File: rtl/a20_gate_sva.sv
// Module: a20_gate_sva
// Property checker for a20_gate_seq, attached with bind below.
// Assumes: synchronous active-low reset.
module a20_gate_sva #(
    parameter logic GATE_RST = 1'b1
) (
    input logic clk,
    input logic rst_n,
    input logic enabled,
    input logic gate_out,
    input logic wr_strobe,
    input logic wr_swallow
);

    // R10: the swallow flag never appears without a write strobe.
    a_r10_swallow_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        wr_swallow |-> wr_strobe);

    // R10: the gate level changes only in a swallowed cycle.
    a_r10_gate_moves_on_swallow: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gate_out) |-> wr_swallow);

    // R2: nothing is swallowed while the block is disabled.
    a_r2_no_swallow_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        wr_swallow |-> enabled);

    // R2: the gate holds its level while the block is disabled.
    a_r2_gate_held_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !enabled |=> $stable(gate_out));

    // R3: once enabled, the block stays enabled.
    a_r3_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        enabled |=> enabled);

    // R9: a write strobe lasts exactly one cycle.
    a_r9_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |=> !wr_strobe);

    // R1: the block leaves reset disabled with the gate at its reset level.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!enabled && gate_out == GATE_RST && !wr_strobe && !wr_swallow));

endmodule

bind a20_gate_seq a20_gate_sva #(
    .GATE_RST (GATE_RST)
) i_a20_gate_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .enabled    (gate_enabled),
    .gate_out   (gate_out),
    .wr_strobe  (wr_strobe),
    .wr_swallow (wr_swallow)
);

// File: tb/test_a20_gate_seq.sv
// Bench: directed scenarios for a20_gate_seq, one task per scenario.
module test_a20_gate_seq;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr_n = 1'b1;
    logic       host_cs_n = 1'b1;
    logic       host_a0 = 1'b0;
    logic [7:0] host_data = 8'h00;
    logic       cpu_gate_en = 1'b0;
    logic       gate_out;
    logic       wr_strobe;
    logic       wr_swallow;

    int n_checks = 0;
    int n_fail   = 0;
    int n_strobe = 0;
    int n_swallow = 0;
    bit done = 1'b0;

    a20_gate_seq i_a20_gate_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_wr_n   (host_wr_n),
        .host_cs_n   (host_cs_n),
        .host_a0     (host_a0),
        .host_data   (host_data),
        .cpu_gate_en (cpu_gate_en),
        .gate_out    (gate_out),
        .wr_strobe   (wr_strobe),
        .wr_swallow  (wr_swallow)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Count strobe and swallow pulses as the neighbouring buffer would.
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_strobe)  n_strobe++;
            if (wr_swallow) n_swallow++;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One host write; cs_sel=0 selects the block.
    task automatic host_write(input logic a0, input logic [7:0] d, input logic cs_sel = 1'b0);
        @(negedge clk);
        host_cs_n = cs_sel;
        host_a0   = a0;
        host_data = d;
        @(negedge clk);
        host_wr_n = 1'b0;
        idle(3);
        host_wr_n = 1'b1;
        idle(3);
        host_cs_n = 1'b1;
        idle(6);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle(4);
        rst_n = 1'b1;
        idle(2);
    endtask

    task automatic enable_pulse();
        @(negedge clk);
        cpu_gate_en = 1'b1;
        @(negedge clk);
        cpu_gate_en = 1'b0;
        idle(2);
    endtask

    task automatic t_reset_state();
        apply_reset();
        check("R1", "gate after reset", int'(gate_out), 1);
        check("R1", "strobe after reset", int'(wr_strobe), 0);
        check("R1", "swallow after reset", int'(wr_swallow), 0);
    endtask

    task automatic t_disabled_pass();
        int s0 = n_strobe;
        int w0 = n_swallow;
        host_write(1'b1, 8'hD1);
        host_write(1'b0, 8'h00);
        host_write(1'b1, 8'hFF);
        check("R2", "strobes while disabled", n_strobe - s0, 3);
        check("R2", "swallows while disabled", n_swallow - w0, 0);
        check("R2", "gate while disabled", int'(gate_out), 1);
    endtask

    task automatic t_chip_select();
        int s0 = n_strobe;
        host_write(1'b1, 8'hD1, 1'b1);
        host_write(1'b0, 8'h00, 1'b1);
        check("R9", "strobes with cs high", n_strobe - s0, 0);
        host_write(1'b0, 8'h55);
        check("R9", "one strobe per write", n_strobe - s0, 1);
    endtask

    task automatic t_clear_sequence();
        int s0 = n_strobe;
        int w0 = n_swallow;
        host_write(1'b1, 8'hD1);
        check("R4", "arming command swallowed", n_swallow - w0, 1);
        host_write(1'b0, 8'hFD);
        check("R5", "gate cleared by bit 1, other bits ignored", int'(gate_out), 0);
        host_write(1'b1, 8'hFF);
        check("R6", "closing FFh swallowed", n_swallow - w0, 3);
        check("R9", "strobes in clear sequence", n_strobe - s0, 3);
    endtask

    task automatic t_set_sequence();
        int w0 = n_swallow;
        host_write(1'b1, 8'hD1);
        host_write(1'b0, 8'h02);
        check("R5", "gate set by bit 1", int'(gate_out), 1);
        host_write(1'b1, 8'hFF);
        host_write(1'b1, 8'hFF);
        check("R6", "only first FFh swallowed", n_swallow - w0, 3);
    endtask

    task automatic t_double_arm();
        int w0 = n_swallow;
        host_write(1'b1, 8'hD1);
        host_write(1'b1, 8'hD1);
        host_write(1'b0, 8'h00);
        host_write(1'b1, 8'hFF);
        check("R7", "double arm all swallowed", n_swallow - w0, 4);
        check("R7", "gate cleared after double arm", int'(gate_out), 0);
    endtask

    task automatic t_abort();
        int s0 = n_strobe;
        int w0 = n_swallow;
        host_write(1'b1, 8'hD1);
        host_write(1'b1, 8'hAA);
        host_write(1'b0, 8'h02);
        check("R8", "strobes in aborted sequence", n_strobe - s0, 3);
        check("R8", "only arming swallowed", n_swallow - w0, 1);
        check("R8", "gate unchanged after abort", int'(gate_out), 0);
    endtask

    task automatic t_stray_bytes();
        int s0 = n_strobe;
        int w0 = n_swallow;
        host_write(1'b1, 8'hFF);
        check("R6", "stray FFh not swallowed", n_swallow - w0, 0);
        host_write(1'b0, 8'hFF);
        check("R11", "stray data not swallowed", n_swallow - w0, 0);
        check("R11", "gate unchanged by stray data", int'(gate_out), 0);
        check("R11", "stray writes strobed", n_strobe - s0, 2);
    endtask

    task automatic t_sticky_enable();
        int w0 = n_swallow;
        enable_pulse();
        host_write(1'b1, 8'hD1);
        host_write(1'b0, 8'hFE);
        check("R3", "still enabled after second pulse", int'(gate_out), 1);
        check("R3", "swallows after second pulse", n_swallow - w0, 2);
    endtask

    task automatic t_reset_disables();
        int w0 = n_swallow;
        host_write(1'b1, 8'hD1);
        host_write(1'b0, 8'h00);
        check("R3", "gate cleared before reset", int'(gate_out), 0);
        apply_reset();
        check("R1", "gate back high after reset", int'(gate_out), 1);
        w0 = n_swallow;
        host_write(1'b1, 8'hD1);
        host_write(1'b0, 8'h00);
        check("R1", "disabled after reset: no swallow", n_swallow - w0, 0);
        check("R2", "disabled after reset: gate held", int'(gate_out), 1);
    endtask

    initial begin
        t_reset_state();
        t_disabled_pass();
        t_chip_select();
        enable_pulse();
        t_clear_sequence();
        t_set_sequence();
        t_double_arm();
        t_abort();
        t_stray_bytes();
        t_sticky_enable();
        t_reset_disables();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run ends as a failed check.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule